// File: doc/BRIEF.md
# Receive Descriptor-Chain DMA Engine

This block moves received frames from a byte stream into memory. Software builds a linked chain of 16-byte receive descriptors. Each descriptor names a buffer and the descriptor that follows it, and carries a two-bit ownership field. When a frame starts to arrive, the engine fetches the current descriptor through a simple 32-bit word memory port. If the engine owns that descriptor, it stores the frame bytes in the buffer. It then writes back the length and status, hands the descriptor back to software and moves on to the next one. Single-cycle event pulses report each outcome.

Reception begins when a start pulse arrives while receive is enabled. The first descriptor is taken from the list base address. Oversize frames are governed by a long-frame setting: when it is set, such a frame is stored and flagged; when it is clear, the frame is dropped. The reported length always includes four CRC bytes, which the stream itself does not carry. Address filtering, CRC checking and the PHY side are outside this block.

Top module: `rx_desc_dma`

## Requirements
- R1: After reset, `inReady`, `memEn` and all five event outputs are 0, and `curDescAddr` is 0.
- R2: The engine leaves idle only on a `startPulse` cycle with `rxEnable` high, and its first descriptor is read from `listBase`. While `rxEnable` is low between frames, `inReady` stays 0 and the stream is not consumed.
- R3: A descriptor is four little-endian 32-bit words at offsets +0 (status/length), +4 (buffer address), +8 (reserved, never read or written) and +12 (next descriptor address). The engine fetches it when the first byte of a frame is presented.
- R4: Only status bits 31:30 = 2'b10 give the descriptor to the engine. Any other value makes the engine discard the whole frame, write nothing, pulse `evUnavail` and keep `curDescAddr` unchanged.
- R5: Frame byte k is stored at buffer address + k, in little-endian byte lanes with contiguous byte enables. No byte beyond the end of the frame is modified.
- R6: On completion, the status word is written back as follows: bits 31:30 = 2'b00, bit 20 = 1 (received good), bit 19 = too-long flag, bit 16 = interrupt bit, bits 15:0 = payload bytes + 4. All other bits are 0.
- R7: After a write-back, `curDescAddr` equals the next-descriptor address read from offset +12.
- R8: With `longPktEn` = 1, a frame longer than 1518 bytes is stored in full, bit 19 of its status is set, and `evTooLong` pulses together with `evGood`.
- R9: With `longPktEn` = 0, a frame longer than 1518 bytes gets no write-back. At most its first 1518 bytes are stored. `evTooLong` pulses alone and `curDescAddr` is unchanged. A frame of exactly 1518 bytes is accepted normally.
- R10: Events are registered and appear one cycle after their cause. `evEarly` pulses once per stored frame, on its first buffer write. `evGood` and `evIntr` pulse together, once for each written-back descriptor.
- R11: Status bit 16 is set only when `rxIntEn` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rxEnable | input | 1 | Receive enable |
| startPulse | input | 1 | Start demand, one cycle |
| longPktEn | input | 1 | Accept frames longer than 1518 bytes |
| rxIntEn | input | 1 | Set the interrupt bit in written-back status |
| listBase | input | ADDR_W | Address of the first descriptor |
| inValid | input | 1 | Stream byte valid |
| inData | input | 8 | Stream byte |
| inLast | input | 1 | Last byte of the frame |
| inReady | output | 1 | Engine takes the byte this cycle |
| memEn | output | 1 | Memory access request |
| memWe | output | 1 | 1 = write, 0 = read |
| memAddr | output | ADDR_W | Byte address (word aligned) |
| memWdata | output | 32 | Write data |
| memBe | output | 4 | Byte enables |
| memRdata | input | 32 | Read data, valid the cycle after a read |
| curDescAddr | output | ADDR_W | Current descriptor address |
| evGood | output | 1 | Frame received and written back |
| evIntr | output | 1 | Receive interrupt event |
| evEarly | output | 1 | First buffer word of a frame written |
| evTooLong | output | 1 | Frame exceeded 1518 bytes |
| evUnavail | output | 1 | Descriptor not owned, frame discarded |

## Verification
Two functions can land in the same cycle. The byte that completes a buffer word can also be the last byte of the frame, and the byte count can cross the 1518-byte limit on that same final byte. The bench sends frames of 64, 5 and 1518 bytes to cover a full-word end and partial-word ends, and sends 1519 bytes with long frames disallowed. It judges the result from memory contents: the bytes just past each frame and past the 1518-byte limit must be left untouched, and the descriptor status must be written or preserved as the requirements say.

// File: rtl/rx_desc_dma_pkg.sv
package rx_desc_dma_pkg;

  localparam int DATA_W = 32;

  // status word layout
  localparam int OWN_HI   = 31;
  localparam int OWN_LO   = 30;
  localparam int BIT_GOOD = 20;
  localparam int BIT_LONG = 19;
  localparam int BIT_INTR = 16;

  localparam logic [1:0] OWN_ENGINE = 2'b10;
  localparam logic [1:0] OWN_CPU    = 2'b00;

  // descriptor word selectors
  localparam logic [1:0] SEL_STAT = 2'd0;
  localparam logic [1:0] SEL_BUF  = 2'd1;
  localparam logic [1:0] SEL_NEXT = 2'd2;

  typedef enum logic [3:0] {
    ST_IDLE, ST_ARM, ST_RD0, ST_RD1, ST_RD3, ST_CHK, ST_RECV, ST_DISC, ST_WB
  } rxState_t;

  typedef struct packed {
    logic       loadBase;
    logic       rdEn;
    logic [1:0] rdSel;
    logic       capStat;
    logic       capBuf;
    logic       capNext;
    logic       frameClr;
    logic       byteEn;
    logic       writeBack;
  } ctrlStrobe_t;

endpackage

// File: rtl/rx_desc_dma_path.sv
module rx_desc_dma_path
  import rx_desc_dma_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int LEN_W     = 16,
  parameter int MAX_FRAME = 1518,
  parameter int CRC_BYTES = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [ADDR_W-1:0] listBase,
  input  logic              longPktEn,
  input  logic              rxIntEn,
  input  logic [7:0]        inData,
  input  logic              inLast,
  input  logic [DATA_W-1:0] memRdata,
  output logic              memEn,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  output logic [DATA_W/8-1:0] memBe,
  output logic              owned,
  output logic              lenTooLong,
  output logic              frameLong,
  output logic              earlyHit,
  output logic [ADDR_W-1:0] curDescAddr
);

  localparam int LANES  = DATA_W / 8;
  localparam int LANE_W = $clog2(LANES);

  logic [ADDR_W-1:0] curDesc, bufBase, nextDesc;
  logic [1:0]        ownBits;
  logic [LEN_W-1:0]  byteCnt, lenNext, reportLen;
  logic [LANE_W-1:0] lane;
  logic [7:0]        accByte [LANES];
  logic [DATA_W-1:0] mergedWord, statusWord;
  logic [LANES-1:0]  wordBe;
  logic              storeOk, wordWr;
  logic [ADDR_W-1:0] descOff, wordOff;

  assign lane       = byteCnt[LANE_W-1:0];
  assign lenNext    = (byteCnt == '1) ? byteCnt : byteCnt + LEN_W'(1);
  assign lenTooLong = lenNext > LEN_W'(MAX_FRAME);
  assign storeOk    = longPktEn || (byteCnt < LEN_W'(MAX_FRAME));
  assign wordWr     = strobe.byteEn && storeOk &&
                      ((lane == LANE_W'(LANES - 1)) || inLast);
  assign earlyHit   = wordWr && (byteCnt < LEN_W'(LANES));
  assign reportLen  = byteCnt + LEN_W'(CRC_BYTES);
  assign owned      = (ownBits == OWN_ENGINE);
  assign curDescAddr = curDesc;
  assign wordOff    = ADDR_W'({byteCnt[LEN_W-1:LANE_W], {LANE_W{1'b0}}});

  always_comb begin
    case (strobe.rdSel)
      SEL_BUF:  descOff = ADDR_W'(4);
      SEL_NEXT: descOff = ADDR_W'(12);
      default:  descOff = '0;
    endcase
  end

  // per-lane byte accumulators
  for (genvar g = 0; g < LANES; g++) begin : gLane
    always_ff @(posedge clk) begin
      if (!rstN) accByte[g] <= '0;
      else if (strobe.byteEn && lane == LANE_W'(g)) accByte[g] <= inData;
    end
  end

  always_comb begin
    for (int i = 0; i < LANES; i++) begin
      mergedWord[8*i +: 8] = (lane == LANE_W'(i)) ? inData : accByte[i];
      wordBe[i]            = (LANE_W'(i) <= lane);
    end
  end

  always_comb begin
    statusWord                 = '0;
    statusWord[OWN_HI:OWN_LO]  = OWN_CPU;
    statusWord[BIT_GOOD]       = 1'b1;
    statusWord[BIT_LONG]       = frameLong;
    statusWord[BIT_INTR]       = rxIntEn;
    statusWord[LEN_W-1:0]      = reportLen;
  end

  // memory port mux
  always_comb begin
    memEn    = 1'b0;
    memWe    = 1'b0;
    memAddr  = curDesc;
    memWdata = '0;
    memBe    = '0;
    if (strobe.writeBack) begin
      memEn = 1'b1; memWe = 1'b1; memWdata = statusWord; memBe = '1;
    end else if (strobe.rdEn) begin
      memEn = 1'b1; memAddr = curDesc + descOff;
    end else if (wordWr) begin
      memEn = 1'b1; memWe = 1'b1; memAddr = bufBase + wordOff;
      memWdata = mergedWord; memBe = wordBe;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curDesc   <= '0;
      bufBase   <= '0;
      nextDesc  <= '0;
      ownBits   <= OWN_CPU;
      byteCnt   <= '0;
      frameLong <= 1'b0;
    end else begin
      if (strobe.loadBase)  curDesc  <= listBase;
      if (strobe.capStat)   ownBits  <= memRdata[OWN_HI:OWN_LO];
      if (strobe.capBuf)    bufBase  <= memRdata[ADDR_W-1:0];
      if (strobe.capNext)   nextDesc <= memRdata[ADDR_W-1:0];
      if (strobe.frameClr) begin
        byteCnt   <= '0;
        frameLong <= 1'b0;
      end else if (strobe.byteEn) begin
        byteCnt <= lenNext;
        if (inLast) frameLong <= lenTooLong;
      end
      if (strobe.writeBack) curDesc <= nextDesc;
    end
  end

  AST_STORE_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    (memEn && memWe && !strobe.writeBack && !longPktEn) |->
      (byteCnt < LEN_W'(MAX_FRAME))); // R9

  AST_BE_CONTIG: assert property (@(posedge clk) disable iff (!rstN)
    (memEn && memWe) |->
      (memBe == 4'b0001 || memBe == 4'b0011 || memBe == 4'b0111 ||
       memBe == 4'b1111)); // R5

endmodule

// File: rtl/rx_desc_dma_ctrl.sv
module rx_desc_dma_ctrl
  import rx_desc_dma_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        rxEnable,
  input  logic        startPulse,
  input  logic        longPktEn,
  input  logic        inValid,
  input  logic        inLast,
  input  logic        owned,
  input  logic        lenTooLong,
  input  logic        frameLong,
  input  logic        earlyHit,
  output ctrlStrobe_t strobe,
  output logic        inReady,
  output logic        evGood,
  output logic        evIntr,
  output logic        evEarly,
  output logic        evTooLong,
  output logic        evUnavail
);

  rxState_t state, stateNext;
  logic     dropNow, discardEnd;

  assign dropNow    = (state == ST_RECV) && inValid && inLast &&
                      lenTooLong && !longPktEn;
  assign discardEnd = (state == ST_DISC) && inValid && inLast;

  always_comb begin
    stateNext = state;
    strobe    = '0;
    inReady   = 1'b0;
    case (state)
      ST_IDLE: if (rxEnable && startPulse) begin
        strobe.loadBase = 1'b1;
        stateNext       = ST_ARM;
      end
      ST_ARM: begin
        if (!rxEnable)    stateNext = ST_IDLE;
        else if (inValid) stateNext = ST_RD0;
      end
      ST_RD0: begin
        strobe.rdEn  = 1'b1;
        strobe.rdSel = SEL_STAT;
        stateNext    = ST_RD1;
      end
      ST_RD1: begin
        strobe.capStat = 1'b1;
        strobe.rdEn    = 1'b1;
        strobe.rdSel   = SEL_BUF;
        stateNext      = ST_RD3;
      end
      ST_RD3: begin
        strobe.capBuf = 1'b1;
        strobe.rdEn   = 1'b1;
        strobe.rdSel  = SEL_NEXT;
        stateNext     = ST_CHK;
      end
      ST_CHK: begin
        strobe.capNext  = 1'b1;
        strobe.frameClr = 1'b1;
        stateNext       = owned ? ST_RECV : ST_DISC;
      end
      ST_RECV: begin
        inReady       = 1'b1;
        strobe.byteEn = inValid;
        if (inValid && inLast) stateNext = dropNow ? ST_ARM : ST_WB;
      end
      ST_DISC: begin
        inReady = 1'b1;
        if (discardEnd) stateNext = ST_ARM;
      end
      ST_WB: begin
        strobe.writeBack = 1'b1;
        stateNext        = ST_ARM;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      evGood    <= 1'b0;
      evIntr    <= 1'b0;
      evEarly   <= 1'b0;
      evTooLong <= 1'b0;
      evUnavail <= 1'b0;
    end else begin
      state     <= stateNext;
      evGood    <= (state == ST_WB);
      evIntr    <= (state == ST_WB);
      evEarly   <= earlyHit;
      evTooLong <= ((state == ST_WB) && frameLong) || dropNow;
      evUnavail <= discardEnd;
    end
  end

  AST_START_GATE: assert property (@(posedge clk) disable iff (!rstN)
    ($past(state) == ST_IDLE && state != ST_IDLE) |->
      $past(rxEnable && startPulse)); // R2

  AST_WB_AFTER_LAST: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WB) |-> $past(state == ST_RECV && inValid && inLast)); // R6

  AST_UNAVAIL_FROM_DISC: assert property (@(posedge clk) disable iff (!rstN)
    evUnavail |-> $past(state == ST_DISC)); // R4

  AST_GOOD_NOT_UNAVAIL: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({evGood, evUnavail})); // R10

endmodule

// File: rtl/rx_desc_dma.sv
module rx_desc_dma
  import rx_desc_dma_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int LEN_W     = 16,
  parameter int MAX_FRAME = 1518,
  parameter int CRC_BYTES = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxEnable,
  input  logic              startPulse,
  input  logic              longPktEn,
  input  logic              rxIntEn,
  input  logic [ADDR_W-1:0] listBase,
  input  logic              inValid,
  input  logic [7:0]        inData,
  input  logic              inLast,
  output logic              inReady,
  output logic              memEn,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [31:0]       memWdata,
  output logic [3:0]        memBe,
  input  logic [31:0]       memRdata,
  output logic [ADDR_W-1:0] curDescAddr,
  output logic              evGood,
  output logic              evIntr,
  output logic              evEarly,
  output logic              evTooLong,
  output logic              evUnavail
);

  ctrlStrobe_t strobe;
  logic owned, lenTooLong, frameLong, earlyHit;

  rx_desc_dma_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .rxEnable(rxEnable), .startPulse(startPulse),
    .longPktEn(longPktEn), .inValid(inValid), .inLast(inLast),
    .owned(owned), .lenTooLong(lenTooLong), .frameLong(frameLong),
    .earlyHit(earlyHit), .strobe(strobe), .inReady(inReady),
    .evGood(evGood), .evIntr(evIntr), .evEarly(evEarly),
    .evTooLong(evTooLong), .evUnavail(evUnavail)
  );

  rx_desc_dma_path #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .MAX_FRAME(MAX_FRAME), .CRC_BYTES(CRC_BYTES)
  ) u_path (
    .clk(clk), .rstN(rstN), .strobe(strobe), .listBase(listBase),
    .longPktEn(longPktEn), .rxIntEn(rxIntEn), .inData(inData),
    .inLast(inLast), .memRdata(memRdata), .memEn(memEn), .memWe(memWe),
    .memAddr(memAddr), .memWdata(memWdata), .memBe(memBe), .owned(owned),
    .lenTooLong(lenTooLong), .frameLong(frameLong), .earlyHit(earlyHit),
    .curDescAddr(curDescAddr)
  );

endmodule

// File: tb/rx_desc_dma_bench.sv
module rx_desc_dma_bench;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        rxEnable = 1'b0, startPulse = 1'b0, longPktEn = 1'b0, rxIntEn = 1'b0;
  logic [31:0] listBase = 32'h100;
  logic        inValid = 1'b0, inLast = 1'b0;
  logic [7:0]  inData = 8'h00;
  logic        inReady, memEn, memWe;
  logic [31:0] memAddr, memWdata, memRdata, curDescAddr;
  logic [3:0]  memBe;
  logic        evGood, evIntr, evEarly, evTooLong, evUnavail;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  logic [31:0] mem [0:2047];
  logic [4:0]  expQ [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_desc_dma u_rx_desc_dma (
    .clk(clk), .rstN(rstN), .rxEnable(rxEnable), .startPulse(startPulse),
    .longPktEn(longPktEn), .rxIntEn(rxIntEn), .listBase(listBase),
    .inValid(inValid), .inData(inData), .inLast(inLast), .inReady(inReady),
    .memEn(memEn), .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata),
    .memBe(memBe), .memRdata(memRdata), .curDescAddr(curDescAddr),
    .evGood(evGood), .evIntr(evIntr), .evEarly(evEarly),
    .evTooLong(evTooLong), .evUnavail(evUnavail)
  );

  // memory model: one-cycle read latency, byte-enabled writes
  always @(posedge clk) begin
    if (memEn && !memWe) memRdata <= mem[memAddr[12:2]];
    if (memEn && memWe)
      for (int b = 0; b < 4; b++)
        if (memBe[b]) mem[memAddr[12:2]][8*b +: 8] <= memWdata[8*b +: 8];
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] getByte(input int addr);
    return mem[addr >> 2][8*(addr % 4) +: 8];
  endfunction

  task automatic setDesc(input int addr, input logic [31:0] stat,
                         input logic [31:0] buff, input logic [31:0] nxt);
    mem[addr >> 2]       = stat;
    mem[(addr >> 2) + 1] = buff;
    mem[(addr >> 2) + 2] = 32'hDEADBEEF;
    mem[(addr >> 2) + 3] = nxt;
  endtask

  // monitor: every event cycle must match the next expected event vector
  // vector order {unavail, tooLong, early, intr, good}
  always @(negedge clk) begin
    if (rstN && (evGood | evIntr | evEarly | evTooLong | evUnavail)) begin
      logic [4:0] got;
      got = {evUnavail, evTooLong, evEarly, evIntr, evGood};
      if (expQ.size() == 0) check(1'b0, "R10 unexpected event", 32'(got), 32'h0);
      else begin
        logic [4:0] exp;
        exp = expQ.pop_front();
        check(got == exp, "R10 event vector", 32'(got), 32'(exp));
      end
    end
  end

  // kind: 0 stored, 1 stored long, 2 dropped long, 3 discarded
  task automatic sendFrame(input int len, input logic [7:0] seed, input int kind);
    case (kind)
      0: begin expQ.push_back(5'b00100); expQ.push_back(5'b00011); end
      1: begin expQ.push_back(5'b00100); expQ.push_back(5'b01011); end
      2: begin expQ.push_back(5'b00100); expQ.push_back(5'b01000); end
      default: expQ.push_back(5'b10000);
    endcase
    for (int i = 0; i < len; i++) begin
      inValid = 1'b1;
      inData  = 8'(seed + 8'(i));
      inLast  = (i == len - 1);
      while (!inReady) @(negedge clk);
      @(negedge clk);
    end
    inValid = 1'b0;
    inLast  = 1'b0;
    repeat (12) @(negedge clk);
  endtask

  task automatic checkBytes(input int base, input int len, input logic [7:0] seed,
                            input string req);
    int errs = 0;
    int firstBad = -1;
    for (int i = 0; i < len; i++)
      if (getByte(base + i) !== 8'(seed + 8'(i))) begin
        errs++;
        if (firstBad < 0) firstBad = i;
      end
    check(errs == 0, req, 32'(errs), 32'd0);
  endtask

  initial begin
    for (int i = 0; i < 2048; i++) mem[i] = 32'hEEEEEEEE;
    memRdata = '0;
    setDesc(32'h100, 32'h8000_0000, 32'h800,  32'h110);
    setDesc(32'h110, 32'h8000_0000, 32'h1000, 32'h120);
    setDesc(32'h120, 32'hC000_0000, 32'h800,  32'h130);
    setDesc(32'h130, 32'h8000_0000, 32'h1000, 32'h100);

    repeat (3) @(negedge clk);
    // R1: reset state
    check(inReady == 0, "R1 inReady", 32'(inReady), 0);
    check(memEn == 0, "R1 memEn", 32'(memEn), 0);
    check({evGood, evIntr, evEarly, evTooLong, evUnavail} == 0, "R1 events",
          32'({evGood, evIntr, evEarly, evTooLong, evUnavail}), 0);
    check(curDescAddr == 0, "R1 curDescAddr", curDescAddr, 0);
    rstN = 1'b1;
    @(negedge clk);

    // R2: start pulse without enable leaves engine idle
    startPulse = 1'b1; @(negedge clk); startPulse = 1'b0;
    inValid = 1'b1;
    begin
      int readySeen = 0;
      repeat (8) begin @(negedge clk); if (inReady) readySeen++; end
      check(readySeen == 0, "R2 start ignored while disabled", readySeen, 0);
    end
    inValid = 1'b0;
    @(negedge clk);

    rxEnable = 1'b1;
    startPulse = 1'b1; @(negedge clk); startPulse = 1'b0;

    // frame A: 64 bytes, whole-word end, interrupts off
    sendFrame(64, 8'h10, 0);
    check(mem[32'h100 >> 2] == 32'h0010_0044, "R6 R11 status frame A",
          mem[32'h100 >> 2], 32'h0010_0044);
    checkBytes(32'h800, 64, 8'h10, "R5 buffer frame A");
    check(getByte(32'h840) == 8'hEE, "R5 byte after frame A", 32'(getByte(32'h840)), 32'hEE);
    check(mem[(32'h100 >> 2) + 2] == 32'hDEADBEEF, "R3 reserved word kept",
          mem[(32'h100 >> 2) + 2], 32'hDEADBEEF);
    check(curDescAddr == 32'h110, "R2 R7 advance after A", curDescAddr, 32'h110);

    // frame B: 5 bytes, partial last word, interrupts on
    rxIntEn = 1'b1;
    sendFrame(5, 8'h80, 0);
    check(mem[32'h110 >> 2] == 32'h0011_0009, "R6 R11 status frame B",
          mem[32'h110 >> 2], 32'h0011_0009);
    checkBytes(32'h1000, 5, 8'h80, "R5 buffer frame B");
    check(getByte(32'h1005) == 8'hEE, "R5 byte after frame B", 32'(getByte(32'h1005)), 32'hEE);
    check(curDescAddr == 32'h120, "R7 advance after B", curDescAddr, 32'h120);

    // frame C: descriptor owner 2'b11 is not the engine's
    sendFrame(10, 8'h40, 3);
    check(mem[32'h120 >> 2] == 32'hC000_0000, "R4 unowned status untouched",
          mem[32'h120 >> 2], 32'hC000_0000);
    check(curDescAddr == 32'h120, "R4 no advance on discard", curDescAddr, 32'h120);

    // give it to the engine; 1519 bytes without long frames: dropped
    setDesc(32'h120, 32'h8000_0000, 32'h800, 32'h130);
    sendFrame(1519, 8'h33, 2);
    check(mem[32'h120 >> 2] == 32'h8000_0000, "R9 no writeback on drop",
          mem[32'h120 >> 2], 32'h8000_0000);
    check(curDescAddr == 32'h120, "R9 no advance on drop", curDescAddr, 32'h120);
    check(getByte(32'h800 + 1518) == 8'hEE, "R9 store bound at 1518",
          32'(getByte(32'h800 + 1518)), 32'hEE);

    // exactly 1518 bytes: accepted
    sendFrame(1518, 8'h21, 0);
    check(mem[32'h120 >> 2] == 32'h0011_05F2, "R9 status at 1518",
          mem[32'h120 >> 2], 32'h0011_05F2);
    checkBytes(32'h800, 1518, 8'h21, "R5 buffer 1518");
    check(curDescAddr == 32'h130, "R7 advance after 1518", curDescAddr, 32'h130);

    // 1600 bytes with long frames allowed
    longPktEn = 1'b1;
    sendFrame(1600, 8'h2A, 1);
    check(mem[32'h130 >> 2] == 32'h0019_0644, "R8 status long frame",
          mem[32'h130 >> 2], 32'h0019_0644);
    checkBytes(32'h1000, 1600, 8'h2A, "R8 buffer long frame");
    check(curDescAddr == 32'h100, "R7 advance wraps to list head", curDescAddr, 32'h100);

    // R2: disabling stops consumption between frames
    rxEnable = 1'b0;
    repeat (2) @(negedge clk);
    inValid = 1'b1;
    begin
      int readySeen = 0;
      repeat (10) begin @(negedge clk); if (inReady) readySeen++; end
      check(readySeen == 0, "R2 disabled engine takes no bytes", readySeen, 0);
    end
    inValid = 1'b0;
    repeat (4) @(negedge clk);

    check(expQ.size() == 0, "R10 all expected events seen", expQ.size(), 0);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL R1 watchdog expired actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule